// File: doc/BRIEF.md
# Steered Binary Descriptor Generator

This block builds a 256-bit binary descriptor for one keypoint. On an accepted start it captures a 31×31 patch of 8-bit grey levels and a 5-bit orientation interval index. It then runs 256 brightness tests, each comparing two pixels of the patch whose coordinates come from a fixed internal pattern table. Eight tests are evaluated per clock.

Rotation is compensated after the tests, not before them. The finished bit string is rotated left by a multiple of eight positions chosen by the interval index. Matching logic downstream can then compare descriptors directly, and no trigonometry or coordinate rotation is needed.

The interface is control-style rather than a stream. A single-cycle start is honoured only while the block is idle. A busy flag covers the whole job, and a single-cycle done marks the cycle in which the descriptor output first holds the new result. The descriptor output keeps that value until the next done. Back-pressure is not possible here: the caller must keep the result, or keep starts back, as it needs.

Top module: `steered_descriptor`

## Requirements
- R1: While reset is held and after it is released, busy and done are 0 and the descriptor output is all zeros until the first result.
- R2: The test pattern entry for test i (0..255) holds two points, first (ra, ca) and second (rb, cb), each coordinate in 0..30: ra = (7i+3) mod 31, ca = (11i+5) mod 31, rb = (13i+17) mod 31, cb = (19i+23) mod 31. Row r and column c address patch bits [8(31r+c)+7 : 8(31r+c)].
- R3: Raw bit i is 1 when the first point of test i is strictly darker (a smaller unsigned value) than the second, and 0 otherwise. Equal intensities give 0.
- R4: With interval index k, output bit j equals raw bit (j − 8k) mod 256, so the raw string is rotated left by 8k bits. k=0 leaves it unchanged and k=31 rotates it by 248 bits.
- R5: If start is sampled high while idle at clock edge E0, then busy is high from E0 until edge E33, and done and the new descriptor appear at edge E33 (33 cycles after acceptance). Busy falls at that same edge.
- R6: A start that arrives while busy is ignored and produces no extra result. Changes on the patch or orientation inputs after acceptance do not affect the running job.
- R7: Done is high for exactly one cycle per job. The descriptor output changes only at the edge where done rises and holds its value between jobs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to start a job; honoured only while idle |
| patch_i | input | 7688 | 31×31 patch of 8-bit pixels, row-major, pixel (0,0) in the low byte |
| orient_i | input | 5 | Orientation interval index k, 0..31 |
| busy_o | output | 1 | High while a job is running |
| done_o | output | 1 | One-cycle pulse when a new descriptor is valid |
| desc_o | output | 256 | Rotation-compensated descriptor, held until the next done |

## Verification
Each result is due exactly 33 clock edges after the edge that accepts its start. The driver therefore records the expected descriptor together with its due cycle number in a scoreboard when it raises start. The monitor samples on the falling edge. Whenever done is seen, it pops the oldest entry and compares both the descriptor and the current cycle count with the entry, and any done that arrives with an empty scoreboard counts as a failure. This check catches an ignored start that wrongly produces output, and also a result that arrives one cycle early or late.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
  localparam int PATCH_DIM = 31;
  localparam int COORD_W   = 5;

  typedef struct packed {
    logic [COORD_W-1:0] ra;
    logic [COORD_W-1:0] ca;
    logic [COORD_W-1:0] rb;
    logic [COORD_W-1:0] cb;
  } test_pair_t;

  // Sampling point generator for test number i (all coordinates in 0..30).
  function automatic test_pair_t pair_at(int i);
    test_pair_t p;
    p.ra = COORD_W'((7  * i + 3 ) % PATCH_DIM);
    p.ca = COORD_W'((11 * i + 5 ) % PATCH_DIM);
    p.rb = COORD_W'((13 * i + 17) % PATCH_DIM);
    p.cb = COORD_W'((19 * i + 23) % PATCH_DIM);
    return p;
  endfunction
endpackage

// File: rtl/sbd_pattern_rom.sv
module sbd_pattern_rom
  import sbd_pkg::*;
#(
  parameter int NUM_TESTS = 256,
  parameter int LANES     = 8,
  localparam int STEPS    = NUM_TESTS / LANES,
  localparam int STEP_W   = $clog2(STEPS),
  localparam int LANE_W   = $clog2(LANES),
  localparam int ADDR_W   = STEP_W + LANE_W
) (
  input  logic [STEP_W-1:0]            step,
  output test_pair_t [LANES-1:0]       pairs
);
  test_pair_t rom [NUM_TESTS];

  // Constant table contents, computed entry by entry.
  for (genvar e = 0; e < NUM_TESTS; e++) begin : g_entry
    assign rom[e] = pair_at(e);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_read
    logic [ADDR_W-1:0] addr;
    assign addr     = {step, LANE_W'(l)};
    assign pairs[l] = rom[addr];
  end
endmodule

// File: rtl/sbd_test_lanes.sv
module sbd_test_lanes
  import sbd_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int LANES = 8,
  localparam int PATCH_BITS = PATCH_DIM * PATCH_DIM * PIX_W
) (
  input  logic [PATCH_BITS-1:0]   patch,
  input  test_pair_t [LANES-1:0]  pairs,
  output logic [LANES-1:0]        bits
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [PIX_W-1:0] pix_a, pix_b;
    always_comb begin
      pix_a = patch[PIX_W * (int'(pairs[l].ra) * PATCH_DIM + int'(pairs[l].ca)) +: PIX_W];
      pix_b = patch[PIX_W * (int'(pairs[l].rb) * PATCH_DIM + int'(pairs[l].cb)) +: PIX_W];
    end
    // Strictly darker first point yields a one.
    assign bits[l] = (pix_a < pix_b);
  end
endmodule

// File: rtl/sbd_rotator.sv
module sbd_rotator #(
  parameter int DESC_BITS = 256,
  parameter int ORIENT_W  = 5,
  localparam int SHIFT_UNIT = DESC_BITS / (1 << ORIENT_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [DESC_BITS-1:0] raw,
  input  logic [ORIENT_W-1:0]  orient,
  output logic [DESC_BITS-1:0] desc
);
  logic [DESC_BITS-1:0] rot;

  always_comb begin
    for (int j = 0; j < DESC_BITS; j++) begin
      rot[j] = raw[(j + DESC_BITS - int'(orient) * SHIFT_UNIT) % DESC_BITS];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    desc <= '0;
    else if (load) desc <= rot;
  end

  // A rotation never creates or destroys set bits.
  assert_rot_popcount_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ($countones(desc) == $countones($past(raw))));
endmodule

// File: rtl/steered_descriptor.sv
module steered_descriptor
  import sbd_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int DESC_BITS = 256,
  parameter int LANES     = 8,
  parameter int ORIENT_W  = 5,
  localparam int PATCH_BITS = PATCH_DIM * PATCH_DIM * PIX_W,
  localparam int STEPS      = DESC_BITS / LANES,
  localparam int STEP_W     = $clog2(STEPS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [PATCH_BITS-1:0] patch_i,
  input  logic [ORIENT_W-1:0]   orient_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [DESC_BITS-1:0]  desc_o
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_SHIFT} state_t;

  state_t                state_q;
  logic [STEP_W-1:0]     step_q;
  logic [PATCH_BITS-1:0] patch_q;
  logic [ORIENT_W-1:0]   orient_q;
  logic [DESC_BITS-1:0]  raw_q;
  logic                  done_q;
  logic                  accept;
  test_pair_t [LANES-1:0] pairs;
  logic [LANES-1:0]      lane_bits;

  assign accept = start_i && (state_q == S_IDLE);
  assign busy_o = (state_q != S_IDLE);
  assign done_o = done_q;

  sbd_pattern_rom #(.NUM_TESTS(DESC_BITS), .LANES(LANES)) u_rom (
    .step  (step_q),
    .pairs (pairs)
  );

  sbd_test_lanes #(.PIX_W(PIX_W), .LANES(LANES)) u_lanes (
    .patch (patch_q),
    .pairs (pairs),
    .bits  (lane_bits)
  );

  sbd_rotator #(.DESC_BITS(DESC_BITS), .ORIENT_W(ORIENT_W)) u_rot (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (state_q == S_SHIFT),
    .raw    (raw_q),
    .orient (orient_q),
    .desc   (desc_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      step_q   <= '0;
      patch_q  <= '0;
      orient_q <= '0;
      raw_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (accept) begin
          patch_q  <= patch_i;
          orient_q <= orient_i;
          step_q   <= '0;
          state_q  <= S_RUN;
        end
        S_RUN: begin
          raw_q[int'(step_q) * LANES +: LANES] <= lane_bits;
          step_q <= step_q + 1'b1;
          if (step_q == STEP_W'(STEPS - 1)) state_q <= S_SHIFT;
        end
        S_SHIFT: begin
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_desc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(desc_o));
  assert_busy_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
  assert_busy_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(orient_q) && $stable(patch_q)));
endmodule

// File: tb/steered_descriptor_bench.sv
module steered_descriptor_bench;
  localparam int DIM = 31;
  localparam int PB  = DIM * DIM * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [PB-1:0] patch_i = '0;
  logic [4:0]    orient_i = '0;
  logic          busy_o, done_o;
  logic [255:0]  desc_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  logic [7:0]   pix [DIM][DIM];
  logic [255:0] exp_q [$];
  int           due_q [$];
  int unsigned  seed = 32'h1234_5678;

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  steered_descriptor u_steered_descriptor (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .patch_i(patch_i),
    .orient_i(orient_i), .busy_o(busy_o), .done_o(done_o), .desc_o(desc_o)
  );

  task automatic check(bit ok, string req, string what, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Expected descriptor from the stated pattern, compare rule and rotation.
  function automatic logic [255:0] expect_desc(int k);
    logic [255:0] raw, res;
    for (int i = 0; i < 256; i++) begin
      int ra = (7*i+3) % 31, ca = (11*i+5) % 31;
      int rb = (13*i+17) % 31, cb = (19*i+23) % 31;
      raw[i] = (pix[ra][ca] < pix[rb][cb]);
    end
    for (int j = 0; j < 256; j++) res[j] = raw[(j + 256 - 8*k) % 256];
    return res;
  endfunction

  function automatic logic [PB-1:0] flatten();
    logic [PB-1:0] f;
    for (int r = 0; r < DIM; r++)
      for (int c = 0; c < DIM; c++)
        f[8*(r*DIM+c) +: 8] = pix[r][c];
    return f;
  endfunction

  function automatic logic [7:0] rnd8();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[23:16];
  endfunction

  task automatic fill(int mode);
    for (int r = 0; r < DIM; r++)
      for (int c = 0; c < DIM; c++)
        case (mode)
          0: pix[r][c] = 8'(r*8 + c);
          1: pix[r][c] = rnd8();
          2: pix[r][c] = 8'd77;
          default: pix[r][c] = 8'(255 - r*7 - c);
        endcase
  endtask

  // Driver: start a job and push its expected result and due cycle.
  task automatic launch(int k);
    @(negedge clk);
    while (busy_o) @(negedge clk);
    patch_i  = flatten();
    orient_i = 5'(k);
    start_i  = 1'b1;
    exp_q.push_back(expect_desc(k));
    due_q.push_back(cyc + 34);
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o === 1'b1, "R5", "busy after accept", 256'(busy_o), 256'(1));
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: compare each result against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6", "unexpected done", desc_o, '0);
      end else begin
        logic [255:0] e;
        int d;
        e = exp_q.pop_front();
        d = due_q.pop_front();
        check(desc_o === e, "R3/R4", "descriptor", desc_o, e);
        check(cyc == d, "R5", "done cycle", 256'(cyc), 256'(d));
        check(busy_o === 1'b0, "R5", "busy low at done", 256'(busy_o), 256'(0));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check(busy_o === 1'b0, "R1", "busy in reset", 256'(busy_o), 256'(0));
    check(done_o === 1'b0, "R1", "done in reset", 256'(done_o), 256'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check(desc_o === '0, "R1", "desc after reset", desc_o, '0);
    check(busy_o === 1'b0, "R1", "idle after reset", 256'(busy_o), 256'(0));

    // R2/R3/R4: ramp with no rotation
    fill(0); launch(0); drain();
    // R4: random with k=5
    fill(1); launch(5); drain();
    // R3: equal pixels give all zeros regardless of rotation
    fill(2); launch(9); drain();
    check(desc_o === '0, "R3", "flat patch", desc_o, '0);
    // R4: largest interval, rotation 248
    fill(1); launch(31); drain();
    // R6: start and input changes during a job are ignored
    fill(1); launch(3);
    repeat (10) @(negedge clk);
    fill(3);
    patch_i = flatten(); orient_i = 5'd20; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    drain();
    check(busy_o === 1'b0, "R6", "no second job", 256'(busy_o), 256'(0));
    // R7: output holds between jobs
    begin
      logic [255:0] held;
      held = desc_o;
      repeat (5) @(negedge clk);
      check(desc_o === held, "R7", "desc held", desc_o, held);
    end
    // back-to-back jobs
    fill(3); launch(16); launch(1); drain();
    check(exp_q.size() == 0, "R5", "scoreboard empty", 256'(exp_q.size()), '0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule